// File: doc/BRIEF.md
# Edge-Triggered Wakeup Event Controller

This block runs in the always-on clock domain. It watches a large set of wake sources and turns them into one registered wake request for the power sequencer. The sources sit in three banks.

- The pin bank holds external pin lines.
- The interrupt bank holds peripheral interrupt lines.
- The GPIO bank holds secondary GPIO lines. Its enabled, latched events are ORed into one aggregate position (bit 6 by default) of the interrupt bank.

Every source first passes through a two-stage synchronizer. In the pin and interrupt banks, a per-bit polarity selects whether a rising or a falling transition counts as an event. GPIO-bank lines always use the rising transition.

A detected event sets a sticky status bit. Software clears that bit by writing a one to it. A status bit whose enable is set drives the wake request. The aggregate bit wakes the system only when its own interrupt-bank enable is set. Software reaches all registers through a single-cycle write port and a combinational read port. The block needs nothing from the main system clock, so it keeps working while that clock is halted.

Top module: `wake_event_ctrl`

## Requirements
- R1: After reset, these registers read 0: all enables, all pin polarities, all status bits and the wake request. The interrupt polarity reads the default rising mask 0x4C000 (interrupt bits 14, 15 and 18).
- R2: A pin whose polarity bit is 0 latches its status bit on a falling transition.
- R3: A polarity bit of 1 selects the rising transition. The opposite transition of that source sets nothing.
- R4: A status bit stays 1 after its source returns to the idle level, until software clears it.
- R5: Writing to a status register clears each bit written as 1 and leaves each bit written as 0 unchanged. Writing back the value just read clears every pending bit.
- R6: If a new event on a bit and a clear write of that bit take effect on the same clock edge, the bit stays set.
- R7: `wake_o` is a register that holds the OR of (status AND enable) over the pin and interrupt banks. A status bit whose enable is 0 still latches, but it does not wake the system.
- R8: While any GPIO status bit with its GPIO enable set is 1, interrupt status bit 6 (the aggregate) is set on every clock edge. A pending GPIO bit whose enable is 0 does not set the aggregate.
- R9: GPIO-bank status latches on a rising transition. Through the aggregate, it wakes the system only when interrupt enable bit 6 is set.
- R10: Let a source change between two clock edges. Its status reads 1 after the third following edge and not after the second. `wake_o` rises one edge after the status bit.
- R11: Register addresses are as follows. Enable and polarity registers read back the written value truncated to the bank width.

| Address | Register |
|---|---|
| 0 | pin enable |
| 1 | pin polarity |
| 2 | pin status |
| 3 | interrupt enable |
| 4 | interrupt polarity |
| 5 | interrupt status |
| 6 | GPIO enable |
| 7 | GPIO status |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_src | input | PIN_W | Pin-bank wake lines (asynchronous) |
| irq_src | input | IRQ_W | Interrupt-bank wake lines (asynchronous) |
| gpio_src | input | GPIO_W | Secondary GPIO lines (asynchronous) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for reg_addr (combinational) |
| wake_o | output | 1 | Registered wake request |

## Verification
The bench aims a source transition so that its event lands on the same edge as a write-one-to-clear of that bit. A design that lets the clear win would silently drop a wake event.

It writes zeros to a pending status register and writes back a read value. A design that treats the status register as a plain register would lose or keep the wrong bits.

It leaves a GPIO line pending while its GPIO enable is 0, and again while the aggregate's interrupt enable is 0. A design that skips either gate would wake the system spuriously.

It counts edges around each transition and checks the opposite edge of a rising-polarity source. Extra or missing synchronizer stages would shift the status and wake timing, and an inverted polarity decode would latch the wrong transition.

// File: rtl/wkc_pkg.sv
`timescale 1ns/1ps
package wkc_pkg;
   typedef enum logic [2:0] {
      RA_PIN_EN   = 3'd0,
      RA_PIN_POL  = 3'd1,
      RA_PIN_STAT = 3'd2,
      RA_IRQ_EN   = 3'd3,
      RA_IRQ_POL  = 3'd4,
      RA_IRQ_STAT = 3'd5,
      RA_GPIO_EN  = 3'd6,
      RA_GPIO_STAT = 3'd7
   } reg_addr_e;
endpackage

// File: rtl/wkc_sync.sv
`timescale 1ns/1ps
module wkc_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= d_i;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[s] <= '0;
         else        stg[s] <= stg[s-1];
      end
   end

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/wkc_event_bank.sv
`timescale 1ns/1ps
module wkc_event_bank #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] src_i,
   input  logic [W-1:0] pol_i,     // 1 = rising, 0 = falling
   input  logic [W-1:0] lvl_set_i, // level-sensitive set (already in domain)
   input  logic [W-1:0] clr_i,     // one-cycle clear mask
   output logic [W-1:0] stat_o
);
   logic [W-1:0] s_q, prev_q, hit, stat_n;

   wkc_sync #(.W(W), .STAGES(STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .d_i(src_i), .q_o(s_q));

   for (genvar b = 0; b < W; b++) begin : g_edge
      assign hit[b] = pol_i[b] ? (s_q[b] & ~prev_q[b])
                               : (~s_q[b] & prev_q[b]);
   end

   // set terms applied after the clear so a coincident event survives
   assign stat_n = (stat_o & ~clr_i) | hit | lvl_set_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         stat_o <= '0;
      end else begin
         prev_q <= s_q;
         stat_o <= stat_n;
      end
   end
endmodule

// File: rtl/wake_event_ctrl.sv
`timescale 1ns/1ps
module wake_event_ctrl
   import wkc_pkg::*;
#(
   parameter int           DW          = 32,
   parameter int           PIN_W       = 25,
   parameter int           IRQ_W       = 20,
   parameter int           GPIO_W      = 29,
   parameter int           AGG_IDX     = 6,
   parameter int           SYNC_STAGES = 2,
   parameter logic [IRQ_W-1:0] IRQ_POL_RST = IRQ_W'(32'h0004_C000)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PIN_W-1:0]  pin_src,
   input  logic [IRQ_W-1:0]  irq_src,
   input  logic [GPIO_W-1:0] gpio_src,
   input  logic              reg_wr,
   input  logic [2:0]        reg_addr,
   input  logic [DW-1:0]     reg_wdata,
   output logic [DW-1:0]     reg_rdata,
   output logic              wake_o
);
   if (PIN_W < 1 || PIN_W > DW)    $error("PIN_W out of range");
   if (IRQ_W < 1 || IRQ_W > DW)    $error("IRQ_W out of range");
   if (GPIO_W < 1 || GPIO_W > DW)  $error("GPIO_W out of range");
   if (AGG_IDX < 0 || AGG_IDX >= IRQ_W) $error("AGG_IDX outside interrupt bank");
   if (SYNC_STAGES < 2)            $error("SYNC_STAGES must be at least 2");

   logic [PIN_W-1:0]  pin_en, pin_pol, pin_stat, pin_clr;
   logic [IRQ_W-1:0]  irq_en, irq_pol, irq_stat, irq_clr, irq_lvl;
   logic [GPIO_W-1:0] gpio_en, gpio_stat, gpio_clr;
   logic              agg;
   logic              unused_wdata_bits;

   assign unused_wdata_bits = ^reg_wdata;

   function automatic logic hit_addr(logic [2:0] a, reg_addr_e r);
      return a == 3'(r);
   endfunction

   // configuration registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_en  <= '0;
         pin_pol <= '0;
         irq_en  <= '0;
         irq_pol <= IRQ_POL_RST;
         gpio_en <= '0;
      end else if (reg_wr) begin
         if (hit_addr(reg_addr, RA_PIN_EN))  pin_en  <= reg_wdata[PIN_W-1:0];
         if (hit_addr(reg_addr, RA_PIN_POL)) pin_pol <= reg_wdata[PIN_W-1:0];
         if (hit_addr(reg_addr, RA_IRQ_EN))  irq_en  <= reg_wdata[IRQ_W-1:0];
         if (hit_addr(reg_addr, RA_IRQ_POL)) irq_pol <= reg_wdata[IRQ_W-1:0];
         if (hit_addr(reg_addr, RA_GPIO_EN)) gpio_en <= reg_wdata[GPIO_W-1:0];
      end
   end

   assign pin_clr  = (reg_wr && hit_addr(reg_addr, RA_PIN_STAT))
                     ? reg_wdata[PIN_W-1:0] : '0;
   assign irq_clr  = (reg_wr && hit_addr(reg_addr, RA_IRQ_STAT))
                     ? reg_wdata[IRQ_W-1:0] : '0;
   assign gpio_clr = (reg_wr && hit_addr(reg_addr, RA_GPIO_STAT))
                     ? reg_wdata[GPIO_W-1:0] : '0;

   // aggregate of enabled secondary events feeds one interrupt-bank bit
   assign agg = |(gpio_stat & gpio_en);
   always_comb begin
      irq_lvl          = '0;
      irq_lvl[AGG_IDX] = agg;
   end

   wkc_event_bank #(.W(PIN_W), .STAGES(SYNC_STAGES)) pin_bank_i (
      .clk(clk), .rst_n(rst_n), .src_i(pin_src), .pol_i(pin_pol),
      .lvl_set_i('0), .clr_i(pin_clr), .stat_o(pin_stat));

   wkc_event_bank #(.W(IRQ_W), .STAGES(SYNC_STAGES)) irq_bank_i (
      .clk(clk), .rst_n(rst_n), .src_i(irq_src), .pol_i(irq_pol),
      .lvl_set_i(irq_lvl), .clr_i(irq_clr), .stat_o(irq_stat));

   wkc_event_bank #(.W(GPIO_W), .STAGES(SYNC_STAGES)) gpio_bank_i (
      .clk(clk), .rst_n(rst_n), .src_i(gpio_src), .pol_i('1),
      .lvl_set_i('0), .clr_i(gpio_clr), .stat_o(gpio_stat));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wake_o <= 1'b0;
      else        wake_o <= |(pin_stat & pin_en) | |(irq_stat & irq_en);
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         3'(RA_PIN_EN):    reg_rdata[PIN_W-1:0]  = pin_en;
         3'(RA_PIN_POL):   reg_rdata[PIN_W-1:0]  = pin_pol;
         3'(RA_PIN_STAT):  reg_rdata[PIN_W-1:0]  = pin_stat;
         3'(RA_IRQ_EN):    reg_rdata[IRQ_W-1:0]  = irq_en;
         3'(RA_IRQ_POL):   reg_rdata[IRQ_W-1:0]  = irq_pol;
         3'(RA_IRQ_STAT):  reg_rdata[IRQ_W-1:0]  = irq_stat;
         3'(RA_GPIO_EN):   reg_rdata[GPIO_W-1:0] = gpio_en;
         default:          reg_rdata[GPIO_W-1:0] = gpio_stat;
      endcase
   end
endmodule

// File: rtl/wkc_checker.sv
`timescale 1ns/1ps
module wkc_checker #(
   parameter int DW = 32, PIN_W = 25, IRQ_W = 20, GPIO_W = 29, AGG_IDX = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [2:0]        reg_addr,
   input logic [DW-1:0]     reg_wdata,
   input logic              wake_o,
   input logic [PIN_W-1:0]  pin_stat,
   input logic [PIN_W-1:0]  pin_en,
   input logic [IRQ_W-1:0]  irq_stat,
   input logic [IRQ_W-1:0]  irq_en,
   input logic [GPIO_W-1:0] gpio_stat,
   input logic [GPIO_W-1:0] gpio_en
);
   logic pin_clr_wr, irq_clr_wr;
   assign pin_clr_wr = reg_wr && reg_addr == 3'd2;
   assign irq_clr_wr = reg_wr && reg_addr == 3'd5;

   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> (!wake_o && pin_stat == '0 && irq_stat == '0));

   assert_pin_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_clr_wr |=> ((pin_stat & $past(pin_stat)) == $past(pin_stat)));

   assert_irq_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_clr_wr |=> ((irq_stat & $past(irq_stat)) == $past(irq_stat)));

   assert_wake_registered_R7: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (wake_o == $past(|(pin_stat & pin_en) | |(irq_stat & irq_en))));

   assert_gpio_aggregate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (|(gpio_stat & gpio_en)) |=> irq_stat[AGG_IDX]);

   assert_en_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 3'd0) |=> pin_en == $past(reg_wdata[PIN_W-1:0]));
endmodule

bind wake_event_ctrl wkc_checker #(
   .DW(DW), .PIN_W(PIN_W), .IRQ_W(IRQ_W), .GPIO_W(GPIO_W), .AGG_IDX(AGG_IDX)
) chk_i (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .wake_o(wake_o),
   .pin_stat(pin_stat), .pin_en(pin_en), .irq_stat(irq_stat), .irq_en(irq_en),
   .gpio_stat(gpio_stat), .gpio_en(gpio_en));

// File: tb/wake_event_ctrl_tb_top.sv
`timescale 1ns/1ps
module wake_event_ctrl_tb_top;
   localparam int DW = 32, PIN_W = 25, IRQ_W = 20, GPIO_W = 29;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [PIN_W-1:0]  pin_src = '1;
   logic [IRQ_W-1:0]  irq_src = '0;
   logic [GPIO_W-1:0] gpio_src = '0;
   logic              reg_wr = 1'b0;
   logic [2:0]        reg_addr = '0;
   logic [DW-1:0]     reg_wdata = '0;
   logic [DW-1:0]     reg_rdata;
   logic              wake_o;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   wake_event_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .pin_src(pin_src), .irq_src(irq_src),
      .gpio_src(gpio_src), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wake_o(wake_o));

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(logic [2:0] a, logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      step(1);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(logic [2:0] a, output logic [31:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic t_reset;
      logic [31:0] d;
      for (int a = 0; a < 8; a++) begin
         rd(3'(a), d);
         chk("R1", d, (a == 4) ? 32'h0004_C000 : 32'h0);
      end
      chk("R1 wake", 32'(wake_o), 0);
   endtask

   task automatic t_regs;
      logic [31:0] d;
      wr(3'd0, 32'hFFFF_FFFF); rd(3'd0, d); chk("R11 pin_en", d, 32'h01FF_FFFF);
      wr(3'd3, 32'hFFFF_FFFF); rd(3'd3, d); chk("R11 irq_en", d, 32'h000F_FFFF);
      wr(3'd0, 0); wr(3'd3, 0);
   endtask

   task automatic t_pin_fall;
      logic [31:0] d;
      pin_src[3] = 1'b0;
      step(2); rd(3'd2, d); chk("R10 not yet", d, 0);
      step(1); rd(3'd2, d); chk("R2 falling latch", d, 32'h8);
      pin_src[3] = 1'b1;
      step(4); rd(3'd2, d); chk("R4 sticky", d, 32'h8);
   endtask

   task automatic t_pol;
      logic [31:0] d;
      wr(3'd4, 32'h0004_C004);
      irq_src[2] = 1'b1; step(4);
      rd(3'd5, d); chk("R3 rising", d, 32'h4);
      irq_src[1] = 1'b1; step(4);
      rd(3'd5, d); chk("R3 opposite edge ignored", d, 32'h4);
      irq_src[1] = 1'b0; step(4);
      rd(3'd5, d); chk("R3 falling on pol0", d, 32'h6);
      irq_src[2] = 1'b0; step(4);
   endtask

   task automatic t_w1c;
      logic [31:0] d;
      wr(3'd2, 32'h0); rd(3'd2, d); chk("R5 zero write keeps", d, 32'h8);
      wr(3'd2, 32'h8); rd(3'd2, d); chk("R5 one clears", d, 0);
      rd(3'd5, d); wr(3'd5, d); rd(3'd5, d); chk("R5 write-back clears", d, 0);
   endtask

   task automatic t_set_wins;
      logic [31:0] d;
      pin_src[3] = 1'b0; step(4);
      pin_src[3] = 1'b1; step(4);
      rd(3'd2, d); chk("R6 setup", d, 32'h8);
      pin_src[3] = 1'b0;
      step(2);
      wr(3'd2, 32'h8);   // clear lands on the same edge as the event
      rd(3'd2, d); chk("R6 set wins", d, 32'h8);
      wr(3'd2, 32'h8); rd(3'd2, d); chk("R5 clear after", d, 0);
      pin_src[3] = 1'b1; step(4);
   endtask

   task automatic t_wake;
      logic [31:0] d;
      pin_src[0] = 1'b0; step(4);
      rd(3'd2, d); chk("R7 latched while disabled", d, 32'h1);
      chk("R7 no wake disabled", 32'(wake_o), 0);
      wr(3'd0, 32'h1); step(1); chk("R7 wake enabled", 32'(wake_o), 1);
      wr(3'd2, 32'h1); step(1); chk("R7 wake drops", 32'(wake_o), 0);
      pin_src[0] = 1'b1; step(3);
      pin_src[0] = 1'b0; step(3);
      chk("R10 wake lags status", 32'(wake_o), 0);
      rd(3'd2, d); chk("R10 status third edge", d, 32'h1);
      step(1); chk("R10 wake fourth edge", 32'(wake_o), 1);
      wr(3'd2, 32'h1); wr(3'd0, 0);
      pin_src[0] = 1'b1; step(4);
   endtask

   task automatic t_gpio;
      logic [31:0] d;
      gpio_src[4] = 1'b1; step(4);
      rd(3'd7, d); chk("R9 gpio rising latch", d, 32'h10);
      rd(3'd5, d); chk("R8 no aggregate when gpio disabled", d, 0);
      wr(3'd6, 32'h10); step(1);
      rd(3'd5, d); chk("R8 aggregate bit 6", d, 32'h40);
      chk("R9 no wake without irq enable", 32'(wake_o), 0);
      wr(3'd3, 32'h40); step(1);
      chk("R9 aggregate wakes", 32'(wake_o), 1);
      wr(3'd5, 32'h40); rd(3'd5, d); chk("R8 aggregate re-sets", d, 32'h40);
      wr(3'd7, 32'h10); wr(3'd5, 32'h40);
      rd(3'd5, d); chk("R8 aggregate cleared", d, 0);
      step(1); chk("R9 wake released", 32'(wake_o), 0);
   endtask

   initial begin
      #(20 * 100000);
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(3);
      t_reset();
      t_regs();
      t_pin_fall();
      t_pol();
      t_w1c();
      t_set_wins();
      t_wake();
      t_gpio();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule